// File: doc/BRIEF.md
# Priority Transition-Rule Match Selector

This block is the decision stage of a programmable byte-at-a-time state machine used for pattern scanning. Each cycle it is given one memory line that packs P transition rules, together with the machine's current state vector, the current 8-bit input character and the class-membership bits already worked out for that character. It tests every rule on the line against these values in parallel. From the rule that matches and sits earliest on the line, it takes the result part: the next state, the next table address and the next hash mask.

Each rule has its own input test. The test can be don't-care, exact, case-insensitive or character-class, and any of these can be inverted. A rule also matches only when its stored state equals the current state and its valid bit is set. When no rule on the line matches, the block passes on a separately supplied default result, which always ranks below every stored rule. The registered output carries the chosen result, a one-hot vector marking the winning slot, and a flag that says the default was used.

Top module: `rsel_top`

## Requirements
- R1: The output is registered. When in_valid is high at a rising clock edge, out_valid is high after that edge. When in_valid is low, out_valid is low after that edge.
- R2: A rule can match only when its 8-bit state field equals state_i exactly.
- R3: Type code 01 (exact) requires char_i to equal the 8-bit operand.
- R4: Type code 10 (case-insensitive) compares char_i with the operand on every bit except bit 5 (value 0x20). A difference in any other bit means no match.
- R5: Type code 11 (class) matches when class_i[operand[2:0]] is 1.
- R6: Type code 00 (don't-care) matches any character.
- R7: When the negate bit is 1, the rule matches only if its base input test fails. A negated don't-care therefore never matches.
- R8: A slot whose valid bit is 0 never matches, whatever its other fields hold.
- R9: When several slots match, the lowest-numbered slot wins. out_slot is one-hot at that slot, and the output result is that slot's result fields.
- R10: When no slot matches, out_used_default is 1, out_slot is 0 and the output result equals dflt_i.
- R11: While rst is high, after each edge out_valid, out_slot, out_used_default and all result outputs are 0.

Each slot in line_i occupies 41 bits, and slot k sits at bits [41k+40:41k]. Within a slot the fields run from the most significant bit down:
- valid (1 bit)
- negate (1 bit)
- type (2 bits)
- state (8 bits)
- operand (8 bits)
- next state (8 bits)
- next table (6 bits)
- next mask (7 bits)

dflt_i holds {next state, next table, next mask}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A line is presented this cycle |
| line_i | input | 164 | P=4 packed rules, slot 0 in the low bits |
| state_i | input | 8 | Current state vector |
| char_i | input | 8 | Current input character |
| class_i | input | 8 | Class-membership bits of char_i |
| dflt_i | input | 21 | Default result {next state, table, mask} |
| out_valid | output | 1 | The result below is valid |
| out_nstate | output | 8 | Selected next state |
| out_ntable | output | 6 | Selected next table address |
| out_nmask | output | 7 | Selected next mask vector |
| out_slot | output | 4 | One-hot winning slot, 0 if the default was used |
| out_used_default | output | 1 | The default result was used |

## Verification
The block holds no state other than its output register, so a fault in the evaluation or selection logic shows up in the very next output cycle. It appears either as the wrong slot bit or a wrong default flag, or as result fields that differ from the chosen slot. A fault in one condition type stays hidden until a rule of that type, and with that negate setting, lands on a line where it decides the winner. The stimulus therefore places rules of each type, both plain and negated, at different slot positions and against characters just beside the boundary, such as a bit-5 difference against a bit-1 difference. A model of the rules is compared with the outputs on every clock.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

    localparam int STATE_W     = 8;
    localparam int TABLE_W     = 6;
    localparam int MASK_W      = 7;
    localparam int CHAR_W      = 8;
    localparam int CLASS_W     = 8;
    localparam int CLASS_IDX_W = $clog2(CLASS_W);

    // the single bit separating ASCII upper and lower case letters
    localparam logic [CHAR_W-1:0] FOLD_BIT = 8'h20;

    typedef enum logic [1:0] {
        KIND_ANY    = 2'b00,
        KIND_EXACT  = 2'b01,
        KIND_NOCASE = 2'b10,
        KIND_CLASS  = 2'b11
    } cond_kind_e;

    typedef struct packed {
        logic [STATE_W-1:0] nstate;
        logic [TABLE_W-1:0] ntable;
        logic [MASK_W-1:0]  nmask;
    } rule_res_t;

    typedef struct packed {
        logic               valid;
        logic               negate;
        cond_kind_e         kind;
        logic [STATE_W-1:0] cstate;
        logic [CHAR_W-1:0]  operand;
        rule_res_t          res;
    } rule_t;

    localparam int RES_W  = $bits(rule_res_t);
    localparam int RULE_W = $bits(rule_t);

    function automatic logic fold_equal(logic [CHAR_W-1:0] a, logic [CHAR_W-1:0] b);
        return ((a ^ b) & ~FOLD_BIT) == '0;
    endfunction

endpackage

// File: rtl/rsel_cond_eval.sv
module rsel_cond_eval
    import rsel_pkg::*;
(
    input  rule_t               rule_i,
    input  logic [STATE_W-1:0]  state_i,
    input  logic [CHAR_W-1:0]   char_i,
    input  logic [CLASS_W-1:0]  class_i,
    output logic                hit_o
);
    logic base_hit;
    logic [CLASS_IDX_W-1:0] cls_idx;

    assign cls_idx = rule_i.operand[CLASS_IDX_W-1:0];

    always_comb begin
        unique case (rule_i.kind)
            KIND_ANY:    base_hit = 1'b1;
            KIND_EXACT:  base_hit = (char_i == rule_i.operand);
            KIND_NOCASE: base_hit = fold_equal(char_i, rule_i.operand);
            KIND_CLASS:  base_hit = class_i[cls_idx];
            default:     base_hit = 1'b0;
        endcase
    end

    assign hit_o = rule_i.valid
                 && (rule_i.cstate == state_i)
                 && (base_hit ^ rule_i.negate);

endmodule

// File: rtl/rsel_prio_pick.sv
module rsel_prio_pick
    import rsel_pkg::*;
#(
    parameter int P = 4
) (
    input  logic      [P-1:0] hit_i,
    input  rule_res_t [P-1:0] res_i,
    input  rule_res_t         dflt_i,
    output rule_res_t         res_o,
    output logic      [P-1:0] onehot_o,
    output logic              used_dflt_o
);
    always_comb begin
        logic found;
        found    = 1'b0;
        res_o    = dflt_i;
        onehot_o = '0;
        for (int k = 0; k < P; k++) begin
            if (hit_i[k] && !found) begin
                found       = 1'b1;
                res_o       = res_i[k];
                onehot_o[k] = 1'b1;
            end
        end
        used_dflt_o = !found;
    end

endmodule

// File: rtl/rsel_top.sv
module rsel_top
    import rsel_pkg::*;
#(
    parameter int P = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [P*RULE_W-1:0]  line_i,
    input  logic [STATE_W-1:0]   state_i,
    input  logic [CHAR_W-1:0]    char_i,
    input  logic [CLASS_W-1:0]   class_i,
    input  logic [RES_W-1:0]     dflt_i,
    output logic                 out_valid,
    output logic [STATE_W-1:0]   out_nstate,
    output logic [TABLE_W-1:0]   out_ntable,
    output logic [MASK_W-1:0]    out_nmask,
    output logic [P-1:0]         out_slot,
    output logic                 out_used_default
);
    rule_t     [P-1:0] rules;
    rule_res_t [P-1:0] slot_res;
    logic      [P-1:0] hits;
    rule_res_t         dflt_res;
    rule_res_t         pick_res;
    logic      [P-1:0] pick_onehot;
    logic              pick_dflt;

    assign rules    = line_i;
    assign dflt_res = dflt_i;

    for (genvar k = 0; k < P; k++) begin : g_slot
        assign slot_res[k] = rules[k].res;
        rsel_cond_eval u_eval (
            .rule_i  (rules[k]),
            .state_i (state_i),
            .char_i  (char_i),
            .class_i (class_i),
            .hit_o   (hits[k])
        );
    end

    rsel_prio_pick #(.P(P)) u_pick (
        .hit_i       (hits),
        .res_i       (slot_res),
        .dflt_i      (dflt_res),
        .res_o       (pick_res),
        .onehot_o    (pick_onehot),
        .used_dflt_o (pick_dflt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid        <= 1'b0;
            out_nstate       <= '0;
            out_ntable       <= '0;
            out_nmask        <= '0;
            out_slot         <= '0;
            out_used_default <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_nstate       <= pick_res.nstate;
                out_ntable       <= pick_res.ntable;
                out_nmask        <= pick_res.nmask;
                out_slot         <= pick_onehot;
                out_used_default <= pick_dflt;
            end
        end
    end

endmodule

// File: rtl/rsel_checker.sv
module rsel_checker
    import rsel_pkg::*;
#(
    parameter int P = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [P*RULE_W-1:0]  line_i,
    input logic [STATE_W-1:0]   state_i,
    input logic [RES_W-1:0]     dflt_i,
    input logic                 out_valid,
    input logic [STATE_W-1:0]   out_nstate,
    input logic [TABLE_W-1:0]   out_ntable,
    input logic [MASK_W-1:0]    out_nmask,
    input logic [P-1:0]         out_slot,
    input logic                 out_used_default
);
    rule_t [P-1:0] rules;
    logic  [RES_W-1:0] out_res;

    assign rules   = line_i;
    assign out_res = {out_nstate, out_ntable, out_nmask};

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_slot_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(out_slot));
    assert_default_flag_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_used_default == (out_slot == '0)));
    assert_default_result_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_used_default) |-> (out_res == $past(dflt_i)));
    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && out_slot == '0 && !out_used_default));

    for (genvar k = 0; k < P; k++) begin : g_chk
        assert_slot_result_R9: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_slot[k]) |-> (out_res == $past(rules[k].res)));
        assert_slot_valid_R8: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_slot[k]) |-> $past(rules[k].valid));
        assert_slot_state_R2: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_slot[k]) |-> $past(rules[k].cstate == state_i));
    end

endmodule

bind rsel_top rsel_checker #(.P(P)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .in_valid         (in_valid),
    .line_i           (line_i),
    .state_i          (state_i),
    .dflt_i           (dflt_i),
    .out_valid        (out_valid),
    .out_nstate       (out_nstate),
    .out_ntable       (out_ntable),
    .out_nmask        (out_nmask),
    .out_slot         (out_slot),
    .out_used_default (out_used_default)
);

// File: tb/rsel_top_tb.sv
module rsel_top_tb;
    localparam int P  = 4;
    localparam int RW = 41;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [P*RW-1:0] line_i = '0;
    logic [7:0]      state_i = '0;
    logic [7:0]      char_i = '0;
    logic [7:0]      class_i = '0;
    logic [20:0]     dflt_i = '0;
    logic            out_valid;
    logic [7:0]      out_nstate;
    logic [5:0]      out_ntable;
    logic [6:0]      out_nmask;
    logic [P-1:0]    out_slot;
    logic            out_used_default;

    int checks = 0;
    int errors = 0;

    logic        have_exp = 1'b0;
    logic        exp_valid;
    logic [20:0] exp_res;
    logic [P-1:0] exp_slot;
    logic        exp_dflt;
    string       exp_tag;

    always #5 clk = ~clk;

    rsel_top #(.P(P)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .line_i(line_i),
        .state_i(state_i), .char_i(char_i), .class_i(class_i), .dflt_i(dflt_i),
        .out_valid(out_valid), .out_nstate(out_nstate), .out_ntable(out_ntable),
        .out_nmask(out_nmask), .out_slot(out_slot), .out_used_default(out_used_default)
    );

    function automatic logic [RW-1:0] mk(input logic v, input logic neg, input logic [1:0] kind,
                                         input logic [7:0] cs, input logic [7:0] op, input int id);
        logic [20:0] res;
        res = {8'h40 + 8'(id), 6'(id + 3), 7'(7'h55 ^ 7'(id))};
        return {v, neg, kind, cs, op, res};
    endfunction

    // behavioural reading of the rule set
    task automatic model(input logic [P*RW-1:0] ln, input logic [7:0] st, input logic [7:0] ch,
                         input logic [7:0] cls, input logic [20:0] df);
        exp_res  = df;
        exp_slot = '0;
        exp_dflt = 1'b1;
        for (int k = P - 1; k >= 0; k--) begin
            logic [RW-1:0] r;
            logic base;
            int diff;
            r = ln[k*RW +: RW];
            diff = int'(ch ^ r[28:21]);
            case (r[38:37])
                2'b00: base = 1'b1;
                2'b01: base = (diff == 0);
                2'b10: base = (diff == 0) || (diff == 32);
                default: base = cls[r[23:21]];
            endcase
            if (r[40] && r[36:29] == st && (base != r[39])) begin
                exp_res  = r[20:0];
                exp_slot = '0;
                exp_slot[k] = 1'b1;
                exp_dflt = 1'b0;
            end
        end
    endtask

    task automatic check_out();
        if (!have_exp) return;
        checks++;
        if (out_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s out_valid actual %0b expected %0b", exp_tag, out_valid, exp_valid);
        end else if (exp_valid && ({out_nstate, out_ntable, out_nmask} !== exp_res
                     || out_slot !== exp_slot || out_used_default !== exp_dflt)) begin
            errors++;
            $display("FAIL %s actual res %h slot %b dflt %b expected res %h slot %b dflt %b",
                     exp_tag, {out_nstate, out_ntable, out_nmask}, out_slot, out_used_default,
                     exp_res, exp_slot, exp_dflt);
        end
    endtask

    task automatic step(input logic v, input logic [P*RW-1:0] ln, input logic [7:0] st,
                        input logic [7:0] ch, input logic [7:0] cls, input string tag);
        @(negedge clk);
        check_out();
        in_valid = v; line_i = ln; state_i = st; char_i = ch; class_i = cls;
        dflt_i = {8'hD0 ^ ch, 6'h2A, 7'h11 ^ st[6:0]};
        model(ln, st, ch, cls, dflt_i);
        exp_valid = v;
        exp_tag = tag;
        have_exp = 1'b1;
    endtask

    function automatic logic [P*RW-1:0] line4(input logic [RW-1:0] a, input logic [RW-1:0] b,
                                              input logic [RW-1:0] c, input logic [RW-1:0] d);
        return {d, c, b, a};
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [RW-1:0] z;
        logic [7:0] S;
        z = '0;
        S = 8'h11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;  // R11 reset state
        if (out_valid !== 1'b0 || out_slot !== '0 || out_used_default !== 1'b0 ||
            {out_nstate, out_ntable, out_nmask} !== '0) begin
            errors++;
            $display("FAIL R11 reset outputs actual %b %b %b expected 0", out_valid, out_slot, out_used_default);
        end
        rst = 1'b0;

        step(1, line4(mk(1,0,2'b01,S,8'h61,0), z, z, z), S, 8'h61, 8'h00, "R3 exact hit");
        step(1, line4(mk(1,0,2'b01,S,8'h61,0), z, z, z), S, 8'h62, 8'h00, "R3 exact miss");
        step(1, line4(z, mk(1,0,2'b10,S,8'h61,1), z, z), S, 8'h41, 8'h00, "R4 fold hit");
        step(1, line4(z, mk(1,0,2'b10,S,8'h61,1), z, z), S, 8'h63, 8'h00, "R4 bit1 miss");
        step(1, line4(z, z, mk(1,0,2'b11,S,8'h03,2), z), S, 8'h30, 8'h08, "R5 class hit");
        step(1, line4(z, z, mk(1,0,2'b11,S,8'h03,2), z), S, 8'h30, 8'hF7, "R5 class miss");
        step(1, line4(z, z, z, mk(1,0,2'b00,S,8'h00,3)), S, 8'hFF, 8'h00, "R6 any");
        step(1, line4(mk(1,1,2'b01,S,8'h61,0), z, z, z), S, 8'h62, 8'h00, "R7 neg hit");
        step(1, line4(mk(1,1,2'b01,S,8'h61,0), z, z, z), S, 8'h61, 8'h00, "R7 neg miss");
        step(1, line4(mk(1,1,2'b00,S,8'h00,0), z, z, z), S, 8'h20, 8'h00, "R7 neg any");
        step(1, line4(mk(1,0,2'b01,8'h12,8'h61,0), z, z, z), S, 8'h61, 8'h00, "R2 state miss");
        step(1, line4(mk(0,0,2'b00,S,8'h00,0), z, z, z), S, 8'h61, 8'h00, "R8 invalid slot");
        step(1, line4(mk(0,0,2'b00,S,8'h00,0), mk(1,0,2'b00,S,8'h00,1), z, z), S, 8'h61, 8'h00, "R8 next valid");
        step(1, line4(z, mk(1,0,2'b01,S,8'h5A,1), z, mk(1,0,2'b00,S,8'h00,3)), S, 8'h5A, 8'h00, "R9 slot1 over slot3");
        step(1, line4(mk(1,0,2'b00,S,0,0), mk(1,0,2'b00,S,0,1), mk(1,0,2'b00,S,0,2), mk(1,0,2'b00,S,0,3)),
             S, 8'h01, 8'h00, "R9 all match");
        step(1, '0, S, 8'h00, 8'h00, "R10 empty line");
        step(0, '0, S, 8'h00, 8'h00, "R1 idle");
        step(1, line4(z, z, mk(1,0,2'b01,S,8'h07,2), z), S, 8'h07, 8'h00, "R1 resume");

        for (int n = 0; n < 400; n++) begin
            logic [P*RW-1:0] ln;
            logic [7:0] st;
            logic [7:0] ch;
            st = 8'($urandom_range(0, 3));
            ch = 8'($urandom_range(0, 7)) | (($urandom_range(0, 1) == 1) ? 8'h20 : 8'h00);
            for (int k = 0; k < P; k++) begin
                logic [7:0] op;
                op = 8'($urandom_range(0, 7)) | (($urandom_range(0, 1) == 1) ? 8'h20 : 8'h00);
                ln[k*RW +: RW] = mk(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                                    2'($urandom_range(0, 3)), 8'($urandom_range(0, 3)), op, k + 4*n);
            end
            step(1'($urandom_range(0, 7) != 0), ln, st, ch, 8'($urandom), "R9 random");
        end
        step(0, '0, 8'h00, 8'h00, 8'h00, "R1 drain");
        @(negedge clk);
        check_out();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule